// File: doc/BRIEF.md
# Per-Pixel ADC Offset Trim Calibrator

This controller finds the offset trim setting for one pixel of a per-pixel ADC array while the sensor sees no signal. A start command gives the pixel index, the search mode, the bin that a zero signal should fall into, and how many samples to take at each setting. The controller then steps its trim output through every code from zero to the top of the range, one code per step. Each code moves the conversion by a fraction of one bin. At each code it waits for the requested number of valid ADC samples and sorts each sample into one of three classes: equal to the target bin, below it, or above it.

It offers two search modes. The edge mode suits a pixel whose noise is well under one bin. It finds the trim codes where the dark results leave the target bin, first toward the bin below and then toward the bin above, and it returns the code halfway between them. The peak mode suits a pixel with moderate noise. It counts target-bin hits at every code and returns the code with the most hits. In both modes the zero-signal level ends up near the middle of the target bin, so the threshold for a one-photon signal falls mid-bin.

At the end of a sweep the controller pulses a completion strobe and presents three results: the pixel index, the chosen trim code, and an error flag. It also keeps driving the chosen trim on its trim output. The outer sequence repeats the run for each pixel. Offset calibration comes first, then gain calibration, then an optional second offset pass.

Top module: `ocal_ctrl`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `trim_code` is 0.
- R2: A `start` in idle latches `pixel_idx`, `cal_mode`, `target_bin` and `samples_per_step`, and sets `trim_code` to 0. The trim then advances by exactly one code after each step, up to the all-ones code. Within a step the trim stays constant until the requested number of samples with `adc_valid` high has been accepted. Samples with `adc_valid` low are ignored.
- R3: A `samples_per_step` value of 0 is treated as 1.
- R4: In edge mode (`cal_mode`=0) the lower edge is the first code at which every sample equals the target bin, provided the previous code had at least one sample below the target.
- R5: In edge mode the upper edge is the last all-target code before the first later code that has at least one sample above the target. It is only recorded once a lower edge exists.
- R6: In edge mode with both edges found, the result is floor((lower+upper)/2) and the error flag is 0.
- R7: In edge mode, if either edge is missing by the end of the sweep, the error flag is 1 and the result trim is 0.
- R8: In peak mode (`cal_mode`=1) the result is the code with the largest target-bin hit count. On a tie, the lowest such code wins.
- R9: In peak mode, if no code produced a target-bin hit, the error flag is 1 and the result trim is 0.
- R10: On completion `done` is high for exactly one cycle. At that point `done_pixel`, `done_trim` and `done_err` carry the result, and `trim_code` equals `done_trim` and holds it until the next start.
- R11: A `start` while `busy` is high has no effect: the running sweep, its latched pixel and its latched target are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a calibration sweep (taken only when idle) |
| pixel_idx | input | PIX_W | Pixel to calibrate |
| cal_mode | input | 1 | 0 = edge search, 1 = peak search |
| target_bin | input | ADC_W | Bin that a zero signal should fall into |
| samples_per_step | input | CNT_W | Valid samples per trim code (0 acts as 1) |
| adc_valid | input | 1 | `adc_code` carries a sample this cycle |
| adc_code | input | ADC_W | Dark-frame ADC result of the pixel |
| trim_code | output | TRIM_W | Offset trim applied to the pixel |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle completion strobe |
| done_pixel | output | PIX_W | Pixel of the finished sweep |
| done_trim | output | TRIM_W | Selected trim code |
| done_err | output | 1 | No valid result could be found |

## Verification
A wrong sample count or a wrong classification inside a step changes the hit statistics. That does not show on the ports until the sweep ends: it appears as a different `done_trim` or a wrongly set `done_err` on the single `done` cycle, one full trim range after start. A wrong step sequence shows earlier, because `trim_code` is visible on every cycle and feeds the bench's ADC model. A skipped or repeated code therefore distorts the samples the design receives and moves the reported edges.

The bench drives a dark-signal model: the ADC result is floor((base + trim + noise)/10), with the noise taken from a fixed four-entry pattern. It compares each result against a reference sweep computed from the requirements. The cases include:
- tie-breaking among equal hit counts;
- missing lower and upper edges;
- gapped `adc_valid`;
- a zero sample count;
- an intruding start.

// File: rtl/ocal_pkg.sv
package ocal_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SAMPLE,
      ST_EVAL,
      ST_RESOLVE,
      ST_REPORT
   } ocal_state_e;

   typedef enum logic {
      MODE_EDGE = 1'b0,
      MODE_PEAK = 1'b1
   } ocal_mode_e;

endpackage

// File: rtl/ocal_classify.sv
module ocal_classify #(
   parameter int ADC_W = 8,
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             take,
   input  logic [ADC_W-1:0] code,
   input  logic [ADC_W-1:0] target,
   output logic [CNT_W-1:0] smp_cnt,
   output logic [CNT_W-1:0] hit_cnt,
   output logic             saw_below,
   output logic             saw_above
);
   localparam int               NCTR    = 2;
   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   logic [NCTR-1:0] bump;
   assign bump = {take && (code == target), take};

   // saturating counters: index 0 counts samples, index 1 counts target hits
   generate
      for (genvar gi = 0; gi < NCTR; gi++) begin : g_ctr
         logic [CNT_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (clr)
               q <= '0;
            else if (bump[gi] && (q != CNT_TOP))
               q <= q + 1'b1;
         end
      end
   endgenerate

   assign smp_cnt = g_ctr[0].q;
   assign hit_cnt = g_ctr[1].q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         saw_below <= 1'b0;
         saw_above <= 1'b0;
      end else if (clr) begin
         saw_below <= 1'b0;
         saw_above <= 1'b0;
      end else if (take) begin
         if (code < target) saw_below <= 1'b1;
         if (code > target) saw_above <= 1'b1;
      end
   end

   // R2
   hit_le_smp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_cnt <= smp_cnt);

   // R2
   idle_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!take && !clr) |=> $stable(smp_cnt));

endmodule

// File: rtl/ocal_edge.sv
module ocal_edge #(
   parameter int TRIM_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              step_ev,
   input  logic [TRIM_W-1:0] trim,
   input  logic              in_all,
   input  logic              any_below,
   input  logic              any_above,
   output logic [TRIM_W-1:0] lo,
   output logic [TRIM_W-1:0] hi,
   output logic              lo_found,
   output logic              hi_found
);
   logic prev_below;
   logic prev_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_below <= 1'b0;
         prev_in    <= 1'b0;
         lo         <= '0;
         hi         <= '0;
         lo_found   <= 1'b0;
         hi_found   <= 1'b0;
      end else if (clr) begin
         prev_below <= 1'b0;
         prev_in    <= 1'b0;
         lo         <= '0;
         hi         <= '0;
         lo_found   <= 1'b0;
         hi_found   <= 1'b0;
      end else if (step_ev) begin
         prev_below <= any_below;
         prev_in    <= in_all;
         if (!lo_found && in_all && prev_below) begin
            lo       <= trim;
            lo_found <= 1'b1;
         end
         if (lo_found && !hi_found && prev_in && any_above) begin
            hi       <= trim - 1'b1;
            hi_found <= 1'b1;
         end
      end
   end

   // R5
   hi_after_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hi_found |-> lo_found);

   // R6
   edge_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hi_found |-> (hi >= lo));

endmodule

// File: rtl/ocal_peak.sv
module ocal_peak #(
   parameter int TRIM_W = 5,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              step_ev,
   input  logic [TRIM_W-1:0] trim,
   input  logic [CNT_W-1:0]  hits,
   output logic [TRIM_W-1:0] best_trim,
   output logic [CNT_W-1:0]  best_cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         best_trim <= '0;
         best_cnt  <= '0;
      end else if (clr) begin
         best_trim <= '0;
         best_cnt  <= '0;
      end else if (step_ev && (hits > best_cnt)) begin
         best_trim <= trim;
         best_cnt  <= hits;
      end
   end

   // R8
   peak_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (best_cnt >= $past(best_cnt)));

endmodule

// File: rtl/ocal_ctrl.sv
module ocal_ctrl
   import ocal_pkg::*;
#(
   parameter int PIX_W  = 12,
   parameter int ADC_W  = 8,
   parameter int TRIM_W = 5,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [PIX_W-1:0]  pixel_idx,
   input  logic              cal_mode,
   input  logic [ADC_W-1:0]  target_bin,
   input  logic [CNT_W-1:0]  samples_per_step,
   input  logic              adc_valid,
   input  logic [ADC_W-1:0]  adc_code,
   output logic [TRIM_W-1:0] trim_code,
   output logic              busy,
   output logic              done,
   output logic [PIX_W-1:0]  done_pixel,
   output logic [TRIM_W-1:0] done_trim,
   output logic              done_err
);
   localparam logic [TRIM_W-1:0] TRIM_TOP = '1;
   localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

   generate
      if (TRIM_W < 2 || TRIM_W > 12) begin : g_bad_trim
         $error("ocal_ctrl: TRIM_W out of range");
      end
      if (ADC_W < 2) begin : g_bad_adc
         $error("ocal_ctrl: ADC_W too small");
      end
      if (CNT_W < 1 || PIX_W < 1) begin : g_bad_cnt
         $error("ocal_ctrl: CNT_W and PIX_W must be positive");
      end
   endgenerate

   ocal_state_e       st_q;
   ocal_mode_e        mode_q;
   logic [PIX_W-1:0]  pix_q;
   logic [ADC_W-1:0]  tgt_q;
   logic [CNT_W-1:0]  nsamp_q;
   logic [TRIM_W-1:0] trim_q;
   logic [TRIM_W-1:0] res_trim_q;
   logic              res_err_q;

   logic              launch;
   logic              take;
   logic              step_end;
   logic              step_ev;
   logic              clr_stats;
   logic [CNT_W-1:0]  smp_cnt;
   logic [CNT_W-1:0]  hit_cnt;
   logic              saw_below;
   logic              saw_above;
   logic              in_all;
   logic [TRIM_W-1:0] lo;
   logic [TRIM_W-1:0] hi;
   logic              lo_found;
   logic              hi_found;
   logic [TRIM_W-1:0] best_trim;
   logic [CNT_W-1:0]  best_cnt;
   logic [TRIM_W:0]   mid_sum;
   logic [TRIM_W-1:0] pick_trim;
   logic              pick_err;

   assign launch    = (st_q == ST_IDLE) && start;
   assign take      = (st_q == ST_SAMPLE) && adc_valid;
   assign step_end  = take && (smp_cnt == (nsamp_q - CNT_ONE));
   assign step_ev   = (st_q == ST_EVAL);
   assign clr_stats = launch || step_ev;
   assign in_all    = (hit_cnt == nsamp_q);

   ocal_classify #(.ADC_W(ADC_W), .CNT_W(CNT_W)) i_classify (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr_stats),
      .take      (take),
      .code      (adc_code),
      .target    (tgt_q),
      .smp_cnt   (smp_cnt),
      .hit_cnt   (hit_cnt),
      .saw_below (saw_below),
      .saw_above (saw_above)
   );

   ocal_edge #(.TRIM_W(TRIM_W)) i_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (launch),
      .step_ev   (step_ev),
      .trim      (trim_q),
      .in_all    (in_all),
      .any_below (saw_below),
      .any_above (saw_above),
      .lo        (lo),
      .hi        (hi),
      .lo_found  (lo_found),
      .hi_found  (hi_found)
   );

   ocal_peak #(.TRIM_W(TRIM_W), .CNT_W(CNT_W)) i_peak (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (launch),
      .step_ev   (step_ev),
      .trim      (trim_q),
      .hits      (hit_cnt),
      .best_trim (best_trim),
      .best_cnt  (best_cnt)
   );

   // result selection, evaluated once the last step has been folded in
   assign mid_sum = {1'b0, lo} + {1'b0, hi};

   always_comb begin
      if (mode_q == MODE_EDGE) begin
         pick_err  = !(lo_found && hi_found);
         pick_trim = pick_err ? '0 : mid_sum[TRIM_W:1];
      end else begin
         pick_err  = (best_cnt == '0);
         pick_trim = pick_err ? '0 : best_trim;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         mode_q     <= MODE_EDGE;
         pix_q      <= '0;
         tgt_q      <= '0;
         nsamp_q    <= CNT_ONE;
         trim_q     <= '0;
         res_trim_q <= '0;
         res_err_q  <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (start) begin
                  pix_q   <= pixel_idx;
                  mode_q  <= ocal_mode_e'(cal_mode);
                  tgt_q   <= target_bin;
                  nsamp_q <= (samples_per_step == '0) ? CNT_ONE : samples_per_step;
                  trim_q  <= '0;
                  st_q    <= ST_SAMPLE;
               end
            end
            ST_SAMPLE: begin
               if (step_end) st_q <= ST_EVAL;
            end
            ST_EVAL: begin
               if (trim_q == TRIM_TOP) begin
                  st_q <= ST_RESOLVE;
               end else begin
                  trim_q <= trim_q + 1'b1;
                  st_q   <= ST_SAMPLE;
               end
            end
            ST_RESOLVE: begin
               res_trim_q <= pick_trim;
               res_err_q  <= pick_err;
               trim_q     <= pick_trim;
               st_q       <= ST_REPORT;
            end
            ST_REPORT: begin
               st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign trim_code  = trim_q;
   assign busy       = (st_q != ST_IDLE);
   assign done       = (st_q == ST_REPORT);
   assign done_pixel = pix_q;
   assign done_trim  = res_trim_q;
   assign done_err   = res_err_q;

   // R2
   trim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_SAMPLE) && !step_end) |=> $stable(trim_code));

   // R2
   trim_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_EVAL) && (trim_q != TRIM_TOP)) |=> (trim_code == $past(trim_code) + 1'b1));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   trim_applied_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (trim_code == done_trim));

   // R7
   err_trim_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_err) |-> (done_trim == '0));

   // R11
   start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(done_pixel) && $stable(tgt_q)));

endmodule

// File: tb/test_ocal_ctrl.sv
module test_ocal_ctrl;
   localparam int PIX_W  = 12;
   localparam int ADC_W  = 8;
   localparam int TRIM_W = 5;
   localparam int CNT_W  = 8;
   localparam int TSTEPS = 1 << TRIM_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [PIX_W-1:0]  pixel_idx = '0;
   logic              cal_mode = 1'b0;
   logic [ADC_W-1:0]  target_bin = '0;
   logic [CNT_W-1:0]  samples_per_step = '0;
   logic              adc_valid = 1'b0;
   logic [ADC_W-1:0]  adc_code = '0;
   logic [TRIM_W-1:0] trim_code;
   logic              busy;
   logic              done;
   logic [PIX_W-1:0]  done_pixel;
   logic [TRIM_W-1:0] done_trim;
   logic              done_err;

   always #2.5 clk = ~clk;

   ocal_ctrl #(.PIX_W(PIX_W), .ADC_W(ADC_W), .TRIM_W(TRIM_W), .CNT_W(CNT_W)) i_ocal_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .pixel_idx(pixel_idx),
      .cal_mode(cal_mode), .target_bin(target_bin), .samples_per_step(samples_per_step),
      .adc_valid(adc_valid), .adc_code(adc_code), .trim_code(trim_code),
      .busy(busy), .done(done), .done_pixel(done_pixel), .done_trim(done_trim),
      .done_err(done_err)
   );

   int    n_chk  = 0;
   int    n_fail = 0;
   int    exp_pix_q[$];
   int    exp_trim_q[$];
   int    exp_err_q[$];
   string exp_req_q[$];

   int cfg_base  = 3;
   bit cfg_noisy = 1'b0;
   bit cfg_gap   = 1'b0;
   int cyc       = 0;
   int smp_k     = 0;
   int last_trim = 0;

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int noise_of(input int k);
      case (k % 4)
         0: return 0;
         1: return 4;
         2: return -4;
         default: return 2;
      endcase
   endfunction

   // dark-signal model: one bin spans ten trim codes
   function automatic int adc_of(input int base, input int t, input int k, input bit noisy);
      int v;
      v = base + t + (noisy ? noise_of(k) : 0);
      if (v < 0) v = 0;
      return v / 10;
   endfunction

   task automatic ref_cal(input int mode, input int tgt, input int n, input int base,
                          input bit noisy, output int rt, output int re);
      int nn, lo, hi, best, bt;
      bit lo_f, hi_f, pb, pin;
      nn = (n == 0) ? 1 : n;
      lo = 0; hi = 0; best = 0; bt = 0;
      lo_f = 0; hi_f = 0; pb = 0; pin = 0;
      for (int t = 0; t < TSTEPS; t++) begin
         int hits;
         bit bl, ab, inall;
         hits = 0; bl = 0; ab = 0;
         for (int k = 0; k < nn; k++) begin
            int c;
            c = adc_of(base, t, k, noisy);
            if (c == tgt) hits++;
            else if (c < tgt) bl = 1;
            else ab = 1;
         end
         inall = (hits == nn);
         if (!lo_f && inall && pb) begin lo = t; lo_f = 1; end
         if (lo_f && !hi_f && pin && ab) begin hi = t - 1; hi_f = 1; end
         pb = bl;
         pin = inall;
         if (hits > best) begin best = hits; bt = t; end
      end
      if (mode == 0) begin
         re = (lo_f && hi_f) ? 0 : 1;
         rt = re ? 0 : (lo + hi) / 2;
      end else begin
         re = (best == 0) ? 1 : 0;
         rt = re ? 0 : bt;
      end
   endtask

   // ADC driver: sample index restarts whenever the trim code moves
   always @(negedge clk) begin
      cyc++;
      if (!busy) begin
         smp_k = 0;
         last_trim = int'(trim_code);
         adc_valid <= 1'b0;
      end else begin
         if (int'(trim_code) != last_trim) begin
            smp_k = 0;
            last_trim = int'(trim_code);
         end
         if (!cfg_gap || (cyc % 3 == 0)) begin
            adc_valid <= 1'b1;
            adc_code  <= ADC_W'(adc_of(cfg_base, int'(trim_code), smp_k, cfg_noisy));
            smp_k++;
         end else begin
            adc_valid <= 1'b0;
            adc_code  <= 8'hEE;
         end
      end
   end

   // monitor: compare each completion against the scoreboard
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (exp_pix_q.size() == 0) begin
            check("R10", "unexpected done", 1, 0);
         end else begin
            int ep, et, ee;
            string rq;
            ep = exp_pix_q.pop_front();
            et = exp_trim_q.pop_front();
            ee = exp_err_q.pop_front();
            rq = exp_req_q.pop_front();
            check(rq, "done_trim", int'(done_trim), et);
            check(rq, "done_err", int'(done_err), ee);
            check("R10", "done_pixel", int'(done_pixel), ep);
            check("R10", "trim_code applied", int'(trim_code), et);
         end
      end
   end

   task automatic run_cal(input int pix, input int mode, input int tgt, input int n,
                          input int base, input bit noisy, input bit gap,
                          input bit intrude, input string req);
      int rt, re;
      cfg_base = base; cfg_noisy = noisy; cfg_gap = gap;
      ref_cal(mode, tgt, n, base, noisy, rt, re);
      exp_pix_q.push_back(pix);
      exp_trim_q.push_back(rt);
      exp_err_q.push_back(re);
      exp_req_q.push_back(req);
      @(negedge clk);
      pixel_idx = PIX_W'(pix);
      cal_mode = mode[0];
      target_bin = ADC_W'(tgt);
      samples_per_step = CNT_W'(n);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (intrude) begin
         repeat (20) @(negedge clk);
         // R11: a second start during the sweep with other pixel and target
         pixel_idx = PIX_W'(pix + 5);
         target_bin = ADC_W'(tgt + 1);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      do @(negedge clk); while (busy);
      @(negedge clk);
      check(req, "queue drained", exp_pix_q.size(), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "busy", int'(busy), 0);
      check("R1", "done", int'(done), 0);
      check("R1", "trim_code", int'(trim_code), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1", "busy after release", int'(busy), 0);

      // R4 R5 R6: edges at 7 and 16, midpoint 11
      run_cal(17, 0, 1, 3, 3, 1'b0, 1'b0, 1'b0, "R6");
      // R6 different base: edges 2 and 11, midpoint 6
      run_cal(40, 0, 1, 2, 8, 1'b0, 1'b0, 1'b0, "R4");
      // R2 R5: gapped valid, target 2, edges 17 and 26
      run_cal(3, 0, 2, 2, 3, 1'b0, 1'b1, 1'b0, "R2");
      // R7: target already met at code 0, no lower edge
      run_cal(5, 0, 0, 2, 3, 1'b0, 1'b0, 1'b0, "R7");
      // R7: no upper edge before the end of the range
      run_cal(6, 0, 3, 2, 3, 1'b0, 1'b0, 1'b0, "R7");
      // R8: noisy samples, tie between codes 11 and 12 keeps 11
      run_cal(9, 1, 1, 4, 3, 1'b1, 1'b0, 1'b0, "R8");
      // R8: noise-free with gaps, all codes 7..16 tie, lowest kept
      run_cal(10, 1, 1, 2, 3, 1'b0, 1'b1, 1'b0, "R8");
      // R9: target never reached
      run_cal(11, 1, 9, 2, 3, 1'b0, 1'b0, 1'b0, "R9");
      // R3: zero samples per step acts as one
      run_cal(12, 0, 1, 0, 3, 1'b0, 1'b0, 1'b0, "R3");
      // R5 with noise in edge mode
      run_cal(13, 0, 1, 4, 3, 1'b1, 1'b0, 1'b0, "R5");
      // R11: intruding start ignored
      run_cal(20, 0, 1, 3, 3, 1'b0, 1'b0, 1'b1, "R11");

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog R2 actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule